// File: doc/BRIEF.md
# Load-linked / store-conditional reservation monitor

This block holds the single reservation of one hardware thread for a load-linked / store-conditional pair. A load-linked event records a reservation on a 16-byte granule. A snoop that hits the same cache line drops the reservation. Each store-conditional gets a verdict: it is forwarded to memory or refused. Each verdict also carries a result code that the pipeline writes back.

Uncacheable store-conditionals skip the reservation check and always go through with their own result code. Refused store-conditionals count toward a livelock counter. That counter raises a one-cycle warning each time the run of consecutive refusals reaches a multiple of a set threshold. Verdicts and the warning are registered and appear one cycle after the request. The reservation state is visible at all times.

Top module: `llsc_monitor`

## Requirements
- R1: Synchronous active-high reset clears the reservation flag, the stored address (to zero), the failure count and all verdict outputs.
- R2: A load-linked event sets the reservation flag and stores its address with the low 4 bits cleared, visible on `resv_valid`/`resv_addr` after the next clock edge.
- R3: A snoop has no effect while the reservation flag is clear.
- R4: While the flag is set, a snoop clears it when the snoop address and the stored address match after masking with the cache-line mask (LINE_BYTES, 64 by default). A snoop to another line leaves the flag set.
- R5: An uncacheable store-conditional is always forwarded with result code 2. It changes neither the reservation nor the failure count.
- R6: A cacheable store-conditional fails when the flag is clear, or when its address with the low 4 bits cleared differs from the stored address. On failure the result code is 0, `sc_forward` is 0 and the flag is cleared.
- R7: A cacheable store-conditional that passes is forwarded with result code 1. It leaves the reservation set and resets the failure count to zero.
- R8: Every WARN_EVERY-th consecutive failure raises `livelock_warn` for exactly one cycle. WARN_EVERY is 100000 by default.
- R9: In one cycle, a snoop is applied before a store-conditional, so a matching snoop makes it fail. A store-conditional is judged before a load-linked in the same cycle, and the load-linked then sets the new reservation.
- R10: `sc_done`, `sc_forward`, `sc_result` and `livelock_warn` are registered and reflect the store-conditional of the previous cycle. With no store-conditional they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-linked event |
| ll_addr | input | ADDR_W | Physical address of the load-linked |
| snoop_valid | input | 1 | Snoop event |
| snoop_addr | input | ADDR_W | Snooped address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional targets uncacheable space |
| sc_done | output | 1 | A verdict is presented this cycle |
| sc_forward | output | 1 | Store goes to memory |
| sc_result | output | 2 | Result code: 0 refused, 1 forwarded, 2 uncacheable |
| livelock_warn | output | 1 | One-cycle warning on the consecutive-failure threshold |
| resv_valid | output | 1 | Reservation flag |
| resv_addr | output | ADDR_W | Stored reservation address |

## Verification
The bench builds the monitor with WARN_EVERY set to 4, keeping LINE_BYTES at 64 and ADDR_W at 64. The small threshold brings the livelock warning within reach of a short run. The bench checks that the warning fires on exactly the fourth consecutive refusal, that it wraps, and that a passing store-conditional or an uncacheable one affects the count correctly. The 64-byte line with a 16-byte granule makes it possible to show a snoop hitting a different granule of the same line.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    SC_REFUSED  = 2'd0,
    SC_ISSUED   = 2'd1,
    SC_UNCACHED = 2'd2
  } sc_code_e;
endpackage

// File: rtl/llsc_reservation.sv
module llsc_reservation #(
  parameter int ADDR_W     = 64,
  parameter int GRAN_BITS  = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              sc_fail_clear,
  output logic              lock_live,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr
);
  localparam int LINE_BITS = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_BITS) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1));

  logic snoop_hit;

  // snoop is applied ahead of any store-conditional in the same cycle
  assign snoop_hit = snoop_valid && resv_valid &&
                     ((snoop_addr & LINE_MASK) == (resv_addr & LINE_MASK));
  assign lock_live = resv_valid && !snoop_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
    end else if (ll_valid) begin
      resv_valid <= 1'b1;
      resv_addr  <= ll_addr & GRAN_MASK;
    end else if (snoop_hit || sc_fail_clear) begin
      resv_valid <= 1'b0;
    end
  end

  // R2: a load-linked leaves a granule-aligned reservation behind
  a_r2_ll_sets: assert property (@(posedge clk) disable iff (rst)
    ll_valid |=> resv_valid && (resv_addr[GRAN_BITS-1:0] == '0));

  // R3: nothing revives a cleared flag except a load-linked
  a_r3_clear_stays: assert property (@(posedge clk) disable iff (rst)
    (!resv_valid && !ll_valid) |=> !resv_valid);

  // R4: a same-line snoop drops the reservation
  a_r4_snoop_clears: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && resv_valid && !ll_valid &&
     ((snoop_addr & LINE_MASK) == (resv_addr & LINE_MASK))) |=> !resv_valid);
endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_uncached,
  input  logic              lock_live,
  input  logic [ADDR_W-1:0] resv_addr,
  output logic              fail_now,
  output logic              pass_now,
  output logic              sc_done,
  output logic              sc_forward,
  output sc_code_e          sc_result
);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1));

  logic     cacheable;
  logic     match;
  sc_code_e code_d;

  assign cacheable = sc_valid && !sc_uncached;
  assign match     = lock_live && ((sc_addr & GRAN_MASK) == resv_addr);
  assign pass_now  = cacheable && match;
  assign fail_now  = cacheable && !match;

  always_comb begin
    code_d = SC_REFUSED;
    if (sc_valid && sc_uncached) code_d = SC_UNCACHED;
    else if (pass_now)           code_d = SC_ISSUED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_done    <= 1'b0;
      sc_forward <= 1'b0;
      sc_result  <= SC_REFUSED;
    end else begin
      sc_done    <= sc_valid;
      sc_forward <= pass_now || (sc_valid && sc_uncached);
      sc_result  <= code_d;
    end
  end

  // R6: a refused verdict never reaches memory
  a_r6_refused_blocked: assert property (@(posedge clk) disable iff (rst)
    (sc_done && sc_result == SC_REFUSED) |-> !sc_forward);

  // R5: uncacheable requests always go through
  a_r5_uncached_fwd: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && sc_uncached) |=> sc_forward && sc_result == SC_UNCACHED);

  // R10: outputs are idle when no request came in
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !sc_done |-> !sc_forward && sc_result == SC_REFUSED);
endmodule

// File: rtl/llsc_fail_counter.sv
module llsc_fail_counter #(
  parameter int WARN_EVERY = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_evt,
  input  logic pass_evt,
  output logic warn
);
  localparam int CNT_W = $clog2(WARN_EVERY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARN_EVERY - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      warn  <= 1'b0;
    end else begin
      warn <= fail_evt && (count == LAST);
      if (pass_evt)       count <= '0;
      else if (fail_evt)  count <= (count == LAST) ? '0 : count + 1'b1;
    end
  end

  // R8: a warning is always caused by a failure one cycle before
  a_r8_warn_cause: assert property (@(posedge clk) disable iff (rst)
    warn |-> $past(fail_evt));

  // R8: the warning never lasts two cycles unless a second wrap could occur
  a_r8_warn_pulse: assert property (@(posedge clk) disable iff (rst)
    (warn && WARN_EVERY > 1) |=> !warn);

  // R7: a pass empties the count
  a_r7_pass_resets: assert property (@(posedge clk) disable iff (rst)
    pass_evt |=> count == '0);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int GRAN_BITS  = 4,
  parameter int LINE_BYTES = 64,
  parameter int WARN_EVERY = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_uncached,
  output logic              sc_done,
  output logic              sc_forward,
  output logic [1:0]        sc_result,
  output logic              livelock_warn,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr
);
  logic     lock_live;
  logic     fail_now;
  logic     pass_now;
  sc_code_e result_q;

  llsc_reservation #(
    .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .LINE_BYTES(LINE_BYTES)
  ) u_resv (
    .clk(clk), .rst(rst),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .sc_fail_clear(fail_now),
    .lock_live(lock_live),
    .resv_valid(resv_valid), .resv_addr(resv_addr)
  );

  llsc_decide #(
    .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)
  ) u_decide (
    .clk(clk), .rst(rst),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .lock_live(lock_live), .resv_addr(resv_addr),
    .fail_now(fail_now), .pass_now(pass_now),
    .sc_done(sc_done), .sc_forward(sc_forward), .sc_result(result_q)
  );

  llsc_fail_counter #(
    .WARN_EVERY(WARN_EVERY)
  ) u_count (
    .clk(clk), .rst(rst),
    .fail_evt(fail_now), .pass_evt(pass_now),
    .warn(livelock_warn)
  );

  assign sc_result = result_q;

  // R9: a store-conditional in the same cycle as a same-line snoop is refused
  a_r9_snoop_first: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !sc_uncached && snoop_valid &&
     (snoop_addr[ADDR_W-1:$clog2(LINE_BYTES)] == resv_addr[ADDR_W-1:$clog2(LINE_BYTES)]))
    |=> !sc_forward);
endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          ll_valid, snoop_valid, sc_valid, sc_uncached;
  logic [AW-1:0] ll_addr, snoop_addr, sc_addr;
  logic          sc_done, sc_forward, livelock_warn, resv_valid;
  logic [1:0]    sc_result;
  logic [AW-1:0] resv_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .GRAN_BITS(4), .LINE_BYTES(64), .WARN_EVERY(4)) i_llsc_monitor (
    .clk(clk), .rst(rst),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .sc_done(sc_done), .sc_forward(sc_forward), .sc_result(sc_result),
    .livelock_warn(livelock_warn),
    .resv_valid(resv_valid), .resv_addr(resv_addr)
  );

  typedef struct packed {
    logic          ll;  logic [AW-1:0] lla;
    logic          sn;  logic [AW-1:0] sna;
    logic          sc;  logic [AW-1:0] sca; logic unc;
    logic          edone; logic efwd; logic [1:0] eres; logic ewarn;
    logic          erv; logic [AW-1:0] era;
  } vec_t;

  localparam int NV = 14;
  // Warning threshold is 4 consecutive refusals; codes 0 refused, 1 forwarded, 2 uncacheable.
  localparam vec_t TBL [NV] = '{
    // R6: store-conditional with no reservation (failure 1)
    '{1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h1000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 64'h0},
    // R2: load-linked aligns to 16 bytes
    '{1'b1, 64'h1237, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 64'h1230},
    // R7: same granule passes, reservation kept, count reset
    '{1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h123C, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 64'h1230},
    // R6: other granule fails and clears flag (failure 1)
    '{1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h1240, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 64'h1230},
    // R2: new reservation
    '{1'b1, 64'h2008, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 64'h2000},
    // R4: snoop on another line keeps the flag
    '{1'b0, 64'h0, 1'b1, 64'h3000, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 64'h2000},
    // R4: snoop on other granule of same line clears
    '{1'b0, 64'h0, 1'b1, 64'h203F, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 64'h2000},
    // R3: snoop with flag clear changes nothing
    '{1'b0, 64'h0, 1'b1, 64'h2000, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 64'h2000},
    // R6: flag clear, matching address still fails (failure 2)
    '{1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h2000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 64'h2000},
    // R5: uncacheable forwards with code 2, count untouched
    '{1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 64'h9999, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 64'h2000},
    // R2: reservation at 0x4000
    '{1'b1, 64'h4000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 64'h4000},
    // R9: snoop first in the same cycle, store fails (failure 3)
    '{1'b0, 64'h0, 1'b1, 64'h4010, 1'b1, 64'h4000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 64'h4000},
    // R9/R8: store judged before load-linked, fails (failure 4 -> warn), then LL sets
    '{1'b1, 64'h5000, 1'b0, 64'h0, 1'b1, 64'h5000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 64'h5000},
    // R8/R10: warning lasts one cycle, idle outputs
    '{1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 64'h5000}
  };

  task automatic check(input string req, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ll, input logic [AW-1:0] lla, input logic sn,
                       input logic [AW-1:0] sna, input logic sc, input logic [AW-1:0] sca,
                       input logic unc);
    ll_valid = ll; ll_addr = lla; snoop_valid = sn; snoop_addr = sna;
    sc_valid = sc; sc_addr = sca; sc_uncached = unc;
  endtask

  task automatic idle();
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  // one cacheable store-conditional, result observed on the next falling edge
  task automatic sc_step(input logic [AW-1:0] a, input logic efwd, input logic ewarn,
                         input string req);
    drive(1'b0, '0, 1'b0, '0, 1'b1, a, 1'b0);
    @(negedge clk);
    check(req, "sc_forward", AW'(sc_forward), AW'(efwd));
    check(req, "livelock_warn", AW'(livelock_warn), AW'(ewarn));
  endtask

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "resv_valid", AW'(resv_valid), '0);
    check("R1", "resv_addr", resv_addr, '0);
    check("R1", "sc_done", AW'(sc_done), '0);
    check("R1", "livelock_warn", AW'(livelock_warn), '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].ll, TBL[i].lla, TBL[i].sn, TBL[i].sna, TBL[i].sc, TBL[i].sca, TBL[i].unc);
      @(negedge clk);
      // R10: verdict registered one cycle after the request
      check("R10", $sformatf("v%0d sc_done", i), AW'(sc_done), AW'(TBL[i].edone));
      check("R6/R7", $sformatf("v%0d sc_forward", i), AW'(sc_forward), AW'(TBL[i].efwd));
      check("R5/R6", $sformatf("v%0d sc_result", i), AW'(sc_result), AW'(TBL[i].eres));
      check("R8", $sformatf("v%0d livelock_warn", i), AW'(livelock_warn), AW'(TBL[i].ewarn));
      check("R2/R4", $sformatf("v%0d resv_valid", i), AW'(resv_valid), AW'(TBL[i].erv));
      check("R2", $sformatf("v%0d resv_addr", i), resv_addr, TBL[i].era);
    end

    // R8: count wrapped at the warning; three more failures stay silent
    sc_step(64'h6000, 1'b0, 1'b0, "R8");
    sc_step(64'h6000, 1'b0, 1'b0, "R8");
    sc_step(64'h6000, 1'b0, 1'b0, "R8");
    // R7: a pass resets the run, so the next warning needs four new failures
    drive(1'b1, 64'h6000, 1'b0, '0, 1'b0, '0, 1'b0);
    @(negedge clk);
    sc_step(64'h6004, 1'b1, 1'b0, "R7");
    check("R7", "resv_valid kept", AW'(resv_valid), AW'(1));
    sc_step(64'h7000, 1'b0, 1'b0, "R8");
    sc_step(64'h7000, 1'b0, 1'b0, "R8");
    sc_step(64'h7000, 1'b0, 1'b0, "R8");
    sc_step(64'h7000, 1'b0, 1'b1, "R8");
    idle();
    @(negedge clk);
    check("R8", "warn one cycle", AW'(livelock_warn), '0);

    // R1: reset mid-run clears a live reservation
    drive(1'b1, 64'h8000, 1'b0, '0, 1'b0, '0, 1'b0);
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    check("R1", "resv_valid after reset", AW'(resv_valid), '0);
    check("R1", "resv_addr after reset", resv_addr, '0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule